// File: doc/BRIEF.md
# Multi-master system bus arbiter

This block sits between one local bus master and a shared system bus that several masters contend for. It watches the local side for system-bus cycle requests, asks for the shared bus, and takes it once it holds priority and the bus is free. When it has the bus, it raises an enable that lets the local command and driver logic onto the system bus. Once it has the bus it keeps it across any number of transfers. It gives the bus up only at the end of a transfer, and only when another master forces it off or when the local processor halts.

On the shared side, a bus request output and an active-low priority input are used for parallel priority resolution. A priority output is daisy-chained to the next lower-priority arbiter. Two wired-AND open-drain lines, busy and common request, are each modelled as a pull-low enable plus the sensed line level. A strap input lets a common request from a lower-priority master force a surrender. All logic runs on the rising edge of the bus clock. The local inputs pass through a synchronizer. The shared-side inputs are registered once.

Top module: `mbus_arbiter`

## Requirements
- R1: While and right after synchronous reset, the outputs are: bus request high (inactive), priority-out high, busy pull 0, common-request pull 0, bus-access enable 0.
- R2: A cycle-request strobe with the system/resident select high causes the bus request to go low and the common-request pull to go to 1 while the block does not own the bus. The same strobe with the select low does neither.
- R3: While requesting, the block takes ownership on the clock after it samples priority-in low and busy high. Taking ownership drives enable 1 and busy pull 1. It never takes ownership while busy is sampled low.
- R4: The bus-access enable is 1 only while the block owns the bus. It stays 0 while the block waits for a grant.
- R5: Priority-out is forced high while the block is requesting or owning. Otherwise it copies priority-in with a two-clock delay.
- R6: The owner never drives its common-request pull to 1.
- R7: If priority-in goes high while the block owns the bus and a transfer is open, the block keeps the bus until the transfer-complete strobe. It then surrenders.
- R8: With no other requester and no halt, the owner keeps the bus indefinitely, including across completed transfers and new cycle requests.
- R9: A halt status seen while no transfer is open makes the owner release the bus. The release happens on the third clock after halt rises.
- R10: With the any-request strap high, a low common-request line that another master drives forces a surrender at the next transfer boundary. With the line tied low, this gives a surrender after every transfer. With the strap low, a low common-request line has no effect on an owner.
- R11: On surrender, the enable drops and the bus request goes high in the same clock. The busy pull stays 1 for exactly one more clock.
- R12: The local strobes pass through SYNC_STAGES flops (default 2). With the default, the bus request goes low on the fourth clock edge after the strobe is first sampled, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req_i | input | 1 | Local cycle-request strobe |
| xfer_done_i | input | 1 | Local transfer-complete strobe |
| halt_i | input | 1 | Local processor halt status |
| sys_sel_i | input | 1 | 1 = cycle targets the system bus, 0 = resident bus |
| any_rq_strap_i | input | 1 | Strap: surrender to any common requester |
| prio_in_n_i | input | 1 | Priority-in, active low |
| busy_n_i | input | 1 | Sensed level of the busy line |
| cbrq_n_i | input | 1 | Sensed level of the common-request line |
| breq_n_o | output | 1 | Bus request, active low |
| prio_out_n_o | output | 1 | Priority-out, active low, to the next arbiter |
| busy_pull_o | output | 1 | 1 = pull the busy line low |
| cbrq_pull_o | output | 1 | 1 = pull the common-request line low |
| bus_en_o | output | 1 | Local command/driver access enable |

## Verification
The hardest state to reach is a priority loss while a transfer is still open. The block must already own the bus with its request still pending, and priority-in must then be withdrawn. The stimulus does this by acquiring the bus and holding back the transfer-complete strobe. It then raises priority-in and waits many clocks before sending the strobe, so that an early surrender would show up. The bench also models the wired-AND lines with the block's own pull. This covers the case where the common-request line is still low from the block's own request just after it takes ownership.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } arb_state_t;

  localparam int LOC_REQ  = 0;
  localparam int LOC_DONE = 1;
  localparam int LOC_SEL  = 2;
  localparam int LOC_HALT = 3;
  localparam int LOC_W    = 4;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/arb_shared_sample.sv
module arb_shared_sample (
  input  logic clk,
  input  logic rst,
  input  logic prio_in_n_i,
  input  logic busy_n_i,
  input  logic cbrq_n_i,
  input  logic strap_i,
  input  logic self_cbrq_i,
  output logic prio_smp_n_o,
  output logic prio_won_o,
  output logic bus_free_o,
  output logic other_cbrq_o,
  output logic strap_o
);

  logic prio_q, busy_q, cbrq_q, strap_q, self_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= 1'b1;
      busy_q  <= 1'b1;
      cbrq_q  <= 1'b1;
      strap_q <= 1'b0;
      self_q  <= 1'b0;
    end else begin
      prio_q  <= prio_in_n_i;
      busy_q  <= busy_n_i;
      cbrq_q  <= cbrq_n_i;
      strap_q <= strap_i;
      self_q  <= self_cbrq_i;
    end
  end

  // the sampled line lags the own pull by one clock; mask the own contribution
  assign prio_smp_n_o = prio_q;
  assign prio_won_o   = ~prio_q;
  assign bus_free_o   = busy_q;
  assign other_cbrq_o = ~cbrq_q & ~self_q;
  assign strap_o      = strap_q;

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_s_i,
  input  logic       done_s_i,
  input  logic       sel_s_i,
  input  logic       halt_s_i,
  input  logic       prio_won_i,
  input  logic       bus_free_i,
  input  logic       other_cbrq_i,
  input  logic       strap_i,
  output arb_state_t state_d_o,
  output logic       pend_o
);

  arb_state_t state_q, state_d;
  logic       pend_q, pend_d;
  logic       boundary, forced_off, leave;

  assign boundary   = done_s_i | ~pend_q;
  assign forced_off = ~prio_won_i | (strap_i & other_cbrq_i);
  assign leave      = boundary & (halt_s_i | forced_off);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pend_q) state_d = ST_REQ;
      ST_REQ:  if (prio_won_i && bus_free_i) state_d = ST_OWN;
      ST_OWN:  if (leave) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (req_s_i && sel_s_i)                pend_d = 1'b1;
    else if (state_q == ST_OWN && done_s_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state_d_o = state_d;
  assign pend_o    = pend_q;

endmodule

// File: rtl/arb_outreg.sv
module arb_outreg
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  arb_state_t state_d_i,
  input  logic       prio_smp_n_i,
  output logic       breq_n_o,
  output logic       prio_out_n_o,
  output logic       busy_pull_o,
  output logic       cbrq_pull_o,
  output logic       bus_en_o
);

  logic wants;
  assign wants = (state_d_i == ST_REQ) || (state_d_i == ST_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      breq_n_o     <= 1'b1;
      prio_out_n_o <= 1'b1;
      busy_pull_o  <= 1'b0;
      cbrq_pull_o  <= 1'b0;
      bus_en_o     <= 1'b0;
    end else begin
      breq_n_o     <= ~wants;
      prio_out_n_o <= wants | prio_smp_n_i;
      busy_pull_o  <= (state_d_i == ST_OWN) || (state_d_i == ST_REL);
      cbrq_pull_o  <= (state_d_i == ST_REQ);
      bus_en_o     <= (state_d_i == ST_OWN);
    end
  end

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_req_i,
  input  logic xfer_done_i,
  input  logic halt_i,
  input  logic sys_sel_i,
  input  logic any_rq_strap_i,
  input  logic prio_in_n_i,
  input  logic busy_n_i,
  input  logic cbrq_n_i,
  output logic breq_n_o,
  output logic prio_out_n_o,
  output logic busy_pull_o,
  output logic cbrq_pull_o,
  output logic bus_en_o
);
  import arb_pkg::*;

  logic [LOC_W-1:0] loc_raw, loc_s;
  logic             done_s, pend_w;
  logic             prio_smp_n, prio_won, bus_free, other_cbrq, strap_q;
  arb_state_t       state_d;

  always_comb begin
    loc_raw           = '0;
    loc_raw[LOC_REQ]  = cyc_req_i;
    loc_raw[LOC_DONE] = xfer_done_i;
    loc_raw[LOC_SEL]  = sys_sel_i;
    loc_raw[LOC_HALT] = halt_i;
  end

  arb_sync #(.WIDTH(LOC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (loc_raw),
    .q_o (loc_s)
  );

  assign done_s = loc_s[LOC_DONE];

  arb_shared_sample u_smp (
    .clk          (clk),
    .rst          (rst),
    .prio_in_n_i  (prio_in_n_i),
    .busy_n_i     (busy_n_i),
    .cbrq_n_i     (cbrq_n_i),
    .strap_i      (any_rq_strap_i),
    .self_cbrq_i  (cbrq_pull_o),
    .prio_smp_n_o (prio_smp_n),
    .prio_won_o   (prio_won),
    .bus_free_o   (bus_free),
    .other_cbrq_o (other_cbrq),
    .strap_o      (strap_q)
  );

  arb_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_s_i      (loc_s[LOC_REQ]),
    .done_s_i     (done_s),
    .sel_s_i      (loc_s[LOC_SEL]),
    .halt_s_i     (loc_s[LOC_HALT]),
    .prio_won_i   (prio_won),
    .bus_free_i   (bus_free),
    .other_cbrq_i (other_cbrq),
    .strap_i      (strap_q),
    .state_d_o    (state_d),
    .pend_o       (pend_w)
  );

  arb_outreg u_out (
    .clk          (clk),
    .rst          (rst),
    .state_d_i    (state_d),
    .prio_smp_n_i (prio_smp_n),
    .breq_n_o     (breq_n_o),
    .prio_out_n_o (prio_out_n_o),
    .busy_pull_o  (busy_pull_o),
    .cbrq_pull_o  (cbrq_pull_o),
    .bus_en_o     (bus_en_o)
  );

endmodule

// File: rtl/mbus_arbiter_chk.sv
module mbus_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic breq_n_o,
  input logic prio_out_n_o,
  input logic busy_pull_o,
  input logic cbrq_pull_o,
  input logic bus_en_o,
  input logic pend_w,
  input logic done_s
);

  // R4
  en_owns_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en_o |-> (busy_pull_o && !breq_n_o));

  // R6
  owner_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en_o |-> !cbrq_pull_o);

  // R5
  chain_block_chk: assert property (@(posedge clk) disable iff (rst)
    !breq_n_o |-> prio_out_n_o);

  // R11
  busy_tail_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_en_o) |-> (busy_pull_o && breq_n_o));

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_en_o) |=> !busy_pull_o);

  // R7
  xfer_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_en_o) |-> $past(done_s || !pend_w));

  // R3
  grant_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en_o) |-> $past(!breq_n_o));

endmodule

bind mbus_arbiter mbus_arbiter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .breq_n_o     (breq_n_o),
  .prio_out_n_o (prio_out_n_o),
  .busy_pull_o  (busy_pull_o),
  .cbrq_pull_o  (cbrq_pull_o),
  .bus_en_o     (bus_en_o),
  .pend_w       (pend_w),
  .done_s       (done_s)
);

// File: tb/sim_mbus_arbiter.sv
module sim_mbus_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_req = 0, xfer_done = 0, halt = 0, sys_sel = 0, strap = 0;
  logic prio_in_n = 1'b1, ext_busy = 1'b0, ext_cbrq = 1'b0;
  logic busy_n, cbrq_n;
  logic breq_n, prio_out_n, busy_pull, cbrq_pull, bus_en;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign busy_n = ~(busy_pull | ext_busy);
  assign cbrq_n = ~(cbrq_pull | ext_cbrq);

  mbus_arbiter u0 (
    .clk(clk), .rst(rst), .cyc_req_i(cyc_req), .xfer_done_i(xfer_done),
    .halt_i(halt), .sys_sel_i(sys_sel), .any_rq_strap_i(strap),
    .prio_in_n_i(prio_in_n), .busy_n_i(busy_n), .cbrq_n_i(cbrq_n),
    .breq_n_o(breq_n), .prio_out_n_o(prio_out_n), .busy_pull_o(busy_pull),
    .cbrq_pull_o(cbrq_pull), .bus_en_o(bus_en)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; cyc_req = 0; xfer_done = 0; halt = 0; sys_sel = 0; strap = 0;
    prio_in_n = 1; ext_busy = 0; ext_cbrq = 0;
    tick(3);
    rst = 0;
  endtask

  task automatic pulse_req(input logic sel);
    sys_sel = sel; cyc_req = 1; tick(1); cyc_req = 0;
  endtask

  task automatic pulse_done();
    xfer_done = 1; tick(1); xfer_done = 0;
  endtask

  // from IDLE with priority held low and bus free: request then own
  task automatic acquire(input string who);
    pulse_req(1'b1);
    tick(2);
    chk({who, " R12 not yet requesting"}, breq_n, 1);
    tick(1);
    chk({who, " R2 requesting breq_n"}, breq_n, 0);
    chk({who, " R2 requesting cbrq pull"}, cbrq_pull, 1);
    chk({who, " R4 no enable while waiting"}, bus_en, 0);
    chk({who, " R5 prio_out blocked"}, prio_out_n, 1);
    tick(1);
    chk({who, " R3 owns enable"}, bus_en, 1);
    chk({who, " R3 busy pulled"}, busy_pull, 1);
    chk({who, " R6 owner no cbrq pull"}, cbrq_pull, 0);
  endtask

  task automatic t_reset();
    rst = 1; tick(2);
    chk("R1 breq_n", breq_n, 1);
    chk("R1 prio_out_n", prio_out_n, 1);
    chk("R1 busy_pull", busy_pull, 0);
    chk("R1 cbrq_pull", cbrq_pull, 0);
    chk("R1 bus_en", bus_en, 0);
    do_reset();
  endtask

  task automatic t_resident();
    do_reset(); prio_in_n = 0; tick(2);
    pulse_req(1'b0);
    tick(6);
    chk("R2 resident no breq", breq_n, 1);
    chk("R2 resident no cbrq pull", cbrq_pull, 0);
    chk("R4 resident no enable", bus_en, 0);
  endtask

  task automatic t_busy_wait();
    do_reset(); prio_in_n = 0; ext_busy = 1; tick(2);
    pulse_req(1'b1);
    tick(6);
    chk("R3 busy low blocks grant", bus_en, 0);
    chk("R2 still requesting", breq_n, 0);
    ext_busy = 0;
    tick(1);
    chk("R3 grant not before sample", bus_en, 0);
    tick(1);
    chk("R3 grant after bus free", bus_en, 1);
    pulse_done(); tick(2);
    chk("R8 kept after transfer", bus_en, 1);
    tick(20);
    chk("R8 kept idle", bus_en, 1);
    pulse_req(1'b1); tick(6);
    chk("R8 kept on new request", bus_en, 1);
    pulse_done(); tick(4);
    chk("R8 kept after second transfer", bus_en, 1);
  endtask

  task automatic t_prio_loss();
    do_reset(); prio_in_n = 0; tick(2);
    acquire("prio_loss");
    prio_in_n = 1;
    tick(10);
    chk("R7 held during open transfer", bus_en, 1);
    pulse_done(); tick(1);
    chk("R7 held until done seen", bus_en, 1);
    tick(1);
    chk("R7 released at boundary", bus_en, 0);
    chk("R11 breq dropped with enable", breq_n, 1);
    chk("R11 busy held one clock", busy_pull, 1);
    tick(1);
    chk("R11 busy released", busy_pull, 0);
    chk("R5 prio_out mirrors high", prio_out_n, 1);
    prio_in_n = 0; tick(1);
    chk("R5 prio_out delay", prio_out_n, 1);
    tick(1);
    chk("R5 prio_out passes low", prio_out_n, 0);
  endtask

  task automatic t_halt();
    do_reset(); prio_in_n = 0; tick(2);
    acquire("halt");
    pulse_done(); tick(3);
    chk("R9 owned before halt", bus_en, 1);
    halt = 1; tick(2);
    chk("R9 not released early", bus_en, 0 + 1);
    tick(1);
    chk("R9 released on halt", bus_en, 0);
    halt = 0; tick(4);
  endtask

  task automatic t_strap();
    do_reset(); prio_in_n = 0; tick(2);
    acquire("strap");
    pulse_done(); tick(3);
    ext_cbrq = 1; strap = 0;
    tick(10);
    chk("R10 strap low ignores cbrq", bus_en, 1);
    chk("R10 strap low busy held", busy_pull, 1);
    strap = 1; tick(1);
    chk("R10 not before strap sampled", bus_en, 1);
    tick(1);
    chk("R10 surrender on cbrq", bus_en, 0);
    tick(3);
    for (int r = 0; r < 2; r++) begin
      acquire("strap_tied");
      tick(5);
      chk("R10 tied low held mid transfer", bus_en, 1);
      pulse_done(); tick(2);
      chk("R10 tied low surrender per transfer", bus_en, 0);
      tick(3);
    end
    strap = 0; ext_cbrq = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_resident();
    t_busy_wait();
    t_prio_loss();
    t_halt();
    t_strap();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule